// File: doc/BRIEF.md
# Interrupt Aggregation Register Block

This block gathers three groups of single-cycle event lines (per-endpoint transmit events, per-endpoint receive events and core bus events) into one 32-bit pending-source register and drives a single level interrupt line from it. Software reads the pending sources through a raw view or a masked view and acknowledges them through write-one-to-clear aliases. It enables or disables them through a mask register that also has write-one-to-set and write-one-to-clear aliases. A write-one-to-set alias on the sources lets software inject any event, for example to start polling on a forced bus-power event.

The interrupt line is gated by an arming flag. Once the line has asserted and then dropped because the sources were serviced, it stays low until software writes the end-of-interrupt register. That write re-arms the line, and if masked sources are still pending the line rises straight away. Register access is a simple synchronous bus: writes are taken at the clock edge while select and write enable are high, and read data is combinational from the address.

Top module: `irqw_top`

## Requirements
- R1: The word offsets are 0x20 raw source (read-only, writes ignored), 0x24 source set, 0x28 source clear, 0x2c mask (read/write), 0x30 mask set, 0x34 mask clear, 0x38 masked source (read-only) and 0x3c end-of-interrupt. Address bits 1:0 are ignored. Every other offset and every write-only alias reads as zero.
- R2: An event line that is high at a clock edge sets its source bit at that edge. Transmit line i maps to bit i (bits 4:0), receive line i to bit 9+i (bits 12:9), and core line i to bit 16+i (bits 24:16). Bit 24 is the bus-power-drive change event.
- R3: A write to 0x24 sets exactly the source bits written as 1, and a write to 0x28 clears exactly the source bits written as 1. All other bits keep their value.
- R4: When an event line and a clear write for the same bit fall on the same edge, the bit ends up set.
- R5: A write to 0x2c replaces the mask, a write to 0x30 sets the mask bits written as 1, and a write to 0x34 clears the mask bits written as 1.
- R6: A read of 0x38 returns the raw source ANDed with the mask.
- R7: Bits 31:25, 15:13 and 8:5 always read as zero in every register, and writing 1 to them has no effect.
- R8: While armed, the interrupt output rises one clock edge after a masked source bit becomes pending. It falls one edge after no masked source bit is pending any more.
- R9: Once the output has fallen, it stays low, even with new masked sources pending, until the end-of-interrupt register is written.
- R10: A write of any data to 0x3c re-arms the output. If a masked source is pending at that edge, the output is high right after the edge.
- R11: After reset the raw source and mask are zero, the output is low and the output is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write enable, taken at the clock edge while bus_sel is high |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tx_evt | input | TX_W (5) | Transmit endpoint event lines |
| rx_evt | input | RX_W (4) | Receive endpoint event lines |
| core_evt | input | CORE_W (9) | Core event lines, the top one being the bus-power-drive change |
| irq_o | output | 1 | Level interrupt output |

## Verification
Some behaviours are checked by assertions on every cycle. These are that an event wins against a same-cycle clear, that a clear without a competing event empties its bits, and that reserved bits never read as 1. They also cover that the output only rises after a masked pending source, that it cannot rise again while disarmed without an end-of-interrupt write, and that such a write with a pending source raises it on the next edge. The bench sweeps every one of the 32 bit positions through the set, clear and mask aliases, and every event line through its field position. Those sweeps show the offset decode, the field map and the masked view. Only the bench scenarios show the full service sequence: assert, clear, stay low with new pending sources, then re-arm.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

   // Register word indices (byte offset >> 2)
   localparam logic [5:0] W_RAW      = 6'h08;
   localparam logic [5:0] W_SRC_SET  = 6'h09;
   localparam logic [5:0] W_SRC_CLR  = 6'h0A;
   localparam logic [5:0] W_MASK     = 6'h0B;
   localparam logic [5:0] W_MASK_SET = 6'h0C;
   localparam logic [5:0] W_MASK_CLR = 6'h0D;
   localparam logic [5:0] W_MASKED   = 6'h0E;
   localparam logic [5:0] W_EOI      = 6'h0F;

   localparam int unsigned DATA_W = 32;

   typedef struct packed {
      logic src_set;
      logic src_clr;
      logic mask_wr;
      logic mask_set;
      logic mask_clr;
      logic eoi;
   } wr_strobe_t;

   // Contiguous field of width w starting at lsb, inside a 32-bit word
   function automatic logic [DATA_W-1:0] field_bits(int unsigned lsb, int unsigned w);
      logic [DATA_W-1:0] v;
      v = '0;
      for (int unsigned i = 0; i < DATA_W; i++) begin
         if (i >= lsb && i < lsb + w) v[i] = 1'b1;
      end
      return v;
   endfunction

endpackage

// File: rtl/irqw_decode.sv
module irqw_decode
   import irqw_pkg::*;
#(
   parameter int unsigned ADDR_W = 8
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output wr_strobe_t        strb,
   output logic [5:0]        word_idx
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("irqw_decode: ADDR_W must be at least 8");
      end
   endgenerate

   logic wr_go;
   logic addr_hi_zero;

   generate
      if (IDX_W > 6) begin : g_wide
         assign addr_hi_zero = ~|bus_addr[ADDR_W-1:8];
      end else begin : g_narrow
         assign addr_hi_zero = 1'b1;
      end
   endgenerate

   assign word_idx = addr_hi_zero ? bus_addr[7:2] : 6'h3F;
   assign wr_go    = bus_sel & bus_we;

   always_comb begin
      strb          = '0;
      strb.src_set  = wr_go && (word_idx == W_SRC_SET);
      strb.src_clr  = wr_go && (word_idx == W_SRC_CLR);
      strb.mask_wr  = wr_go && (word_idx == W_MASK);
      strb.mask_set = wr_go && (word_idx == W_MASK_SET);
      strb.mask_clr = wr_go && (word_idx == W_MASK_CLR);
      strb.eoi      = wr_go && (word_idx == W_EOI);
   end

endmodule

// File: rtl/irqw_bitreg.sv
module irqw_bitreg #(
   parameter int unsigned   W       = 32,
   parameter logic [W-1:0]  KEEP    = '1,
   parameter bit            HAS_EVT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_full,
   input  logic         wr_set,
   input  logic         wr_clr,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] evt,
   output logic [W-1:0] q
);

   generate
      if (W == 0) begin : g_bad_w
         $error("irqw_bitreg: W must be nonzero");
      end
   endgenerate

   logic [W-1:0] evt_use;
   logic [W-1:0] base;
   logic [W-1:0] nxt;

   generate
      if (HAS_EVT) begin : g_evt
         assign evt_use = evt & KEEP;
      end else begin : g_no_evt
         assign evt_use = '0;
      end
   endgenerate

   always_comb begin
      base = wr_full ? wdata : q;
      if (wr_set) base = base | wdata;
      if (wr_clr) base = base & ~wdata;
      nxt = (base | evt_use) & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   // R3: clear without a competing event leaves those bits zero
   a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && !wr_set && !wr_full) |=> ((q & $past(wdata & ~evt_use)) == '0));

   generate
      if (HAS_EVT) begin : g_evt_chk
         // R4: an event always lands, even against a same-cycle clear
         a_r4_evt_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (|evt_use) |=> ((q & $past(evt_use)) == $past(evt_use)));
      end
   endgenerate

endmodule

// File: rtl/irqw_arm.sv
module irqw_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic pend,
   input  logic eoi,
   output logic irq_o
);

   logic armed_q;
   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         irq_q   <= 1'b0;
      end else begin
         irq_q   <= pend & (irq_q | armed_q | eoi);
         armed_q <= eoi | (armed_q & ~pend);
      end
   end

   assign irq_o = irq_q;

   // R8: output high only after a pending masked source
   a_r8_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(pend));

   // R9: disarmed and low stays low without end-of-interrupt
   a_r9_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o && !armed_q && !eoi) |=> !irq_o);

   // R10: end-of-interrupt with a pending source raises the output
   a_r10_eoi_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && pend) |=> irq_o);

endmodule

// File: rtl/irqw_top.sv
module irqw_top
   import irqw_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned TX_W    = 5,
   parameter int unsigned TX_LSB  = 0,
   parameter int unsigned RX_W    = 4,
   parameter int unsigned RX_LSB  = 9,
   parameter int unsigned CORE_W  = 9,
   parameter int unsigned CORE_LSB = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [TX_W-1:0]   tx_evt,
   input  logic [RX_W-1:0]   rx_evt,
   input  logic [CORE_W-1:0] core_evt,
   output logic              irq_o
);

   localparam logic [DATA_W-1:0] TX_BITS   = field_bits(TX_LSB, TX_W);
   localparam logic [DATA_W-1:0] RX_BITS   = field_bits(RX_LSB, RX_W);
   localparam logic [DATA_W-1:0] CORE_BITS = field_bits(CORE_LSB, CORE_W);
   localparam logic [DATA_W-1:0] DEF_BITS  = TX_BITS | RX_BITS | CORE_BITS;

   generate
      if (TX_LSB + TX_W > RX_LSB) begin : g_bad_tx
         $error("irqw_top: transmit field overlaps receive field");
      end
      if (RX_LSB + RX_W > CORE_LSB) begin : g_bad_rx
         $error("irqw_top: receive field overlaps core field");
      end
      if (CORE_LSB + CORE_W > DATA_W) begin : g_bad_core
         $error("irqw_top: core field exceeds data width");
      end
   endgenerate

   wr_strobe_t        strb;
   logic [5:0]        word_idx;
   logic [DATA_W-1:0] evt_vec;
   logic [DATA_W-1:0] src_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] masked;
   logic              pend;

   irqw_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel  (bus_sel),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .strb     (strb),
      .word_idx (word_idx)
   );

   always_comb begin
      evt_vec = '0;
      evt_vec[TX_LSB   +: TX_W]   = tx_evt;
      evt_vec[RX_LSB   +: RX_W]   = rx_evt;
      evt_vec[CORE_LSB +: CORE_W] = core_evt;
   end

   irqw_bitreg #(.W(DATA_W), .KEEP(DEF_BITS), .HAS_EVT(1'b1)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_full (1'b0),
      .wr_set  (strb.src_set),
      .wr_clr  (strb.src_clr),
      .wdata   (bus_wdata),
      .evt     (evt_vec),
      .q       (src_q)
   );

   irqw_bitreg #(.W(DATA_W), .KEEP(DEF_BITS), .HAS_EVT(1'b0)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_full (strb.mask_wr),
      .wr_set  (strb.mask_set),
      .wr_clr  (strb.mask_clr),
      .wdata   (bus_wdata),
      .evt     ('0),
      .q       (mask_q)
   );

   assign masked = src_q & mask_q;
   assign pend   = |masked;

   irqw_arm u_arm (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .eoi   (strb.eoi),
      .irq_o (irq_o)
   );

   always_comb begin
      unique case (word_idx)
         W_RAW:    bus_rdata = src_q;
         W_MASK:   bus_rdata = mask_q;
         W_MASKED: bus_rdata = masked;
         default:  bus_rdata = '0;
      endcase
   end

   // R7: reserved positions never read as one
   a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~DEF_BITS) == '0);

endmodule

// File: tb/irqw_top_test.sv
`timescale 1ns/1ps
module irqw_top_test;

   localparam int unsigned TXW = 5;
   localparam int unsigned RXW = 4;
   localparam int unsigned CW  = 9;
   localparam logic [31:0] DEF = ((32'd1 << TXW) - 1) | (((32'd1 << RXW) - 1) << 9)
                               | (((32'd1 << CW) - 1) << 16);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           bus_sel = 1'b0;
   logic           bus_we = 1'b0;
   logic [7:0]     bus_addr = '0;
   logic [31:0]    bus_wdata = '0;
   logic [31:0]    bus_rdata;
   logic [TXW-1:0] tx_evt = '0;
   logic [RXW-1:0] rx_evt = '0;
   logic [CW-1:0]  core_evt = '0;
   logic           irq_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   irqw_top uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_evt(tx_evt), .rx_evt(rx_evt), .core_evt(core_evt), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      do_reset();

      // R11 reset state
      rd(8'h20, v); chk("R11 raw after reset", v, 32'h0);
      rd(8'h2c, v); chk("R11 mask after reset", v, 32'h0);
      chk("R11 irq after reset", {31'd0, irq_o}, 32'h0);

      // R1 raw source ignores direct writes
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h20, v); chk("R1 raw write ignored", v, 32'h0);

      // R3 / R7 sweep source set and clear per bit
      for (int b = 0; b < 32; b++) begin
         wr(8'h24, 32'd1 << b);
         rd(8'h20, v); chk("R3 R7 src set bit", v, (32'd1 << b) & DEF);
         wr(8'h28, 32'd1 << b);
         rd(8'h20, v); chk("R3 src clear bit", v, 32'h0);
      end

      // R3 set/clear leave other bits alone
      wr(8'h24, 32'h0000_1E1F);
      wr(8'h24, 32'h0100_0000);
      rd(8'h20, v); chk("R3 set keeps others", v, 32'h0100_1E1F);
      wr(8'h28, 32'h0000_0A05);
      rd(8'h20, v); chk("R3 clear keeps others", v, 32'h0100_141A);
      wr(8'h28, 32'hFFFF_FFFF);

      // R5 / R7 sweep mask aliases per bit
      for (int b = 0; b < 32; b++) begin
         wr(8'h30, 32'd1 << b);
         rd(8'h2c, v); chk("R5 R7 mask set bit", v, (32'd1 << b) & DEF);
         wr(8'h34, 32'd1 << b);
         rd(8'h2c, v); chk("R5 mask clear bit", v, 32'h0);
      end
      wr(8'h2c, 32'hFFFF_FFFF);
      rd(8'h2c, v); chk("R5 R7 mask full write", v, DEF);
      wr(8'h2c, 32'h0001_0003);
      rd(8'h2c, v); chk("R5 mask replace", v, 32'h0001_0003);

      // R1 alias and unmapped offsets read zero
      for (int a = 0; a < 64; a++) begin
         logic [7:0] ad;
         ad = 8'(a << 2);
         if (ad != 8'h20 && ad != 8'h2c && ad != 8'h38) begin
            rd(ad, v); chk("R1 non-readable offset", v, 32'h0);
         end
      end
      rd(8'h2f, v); chk("R1 low address bits ignored", v, 32'h0001_0003);

      // R6 masked view over several patterns
      for (int p = 0; p < 6; p++) begin
         logic [31:0] sa, mb;
         sa = 32'h9E5A_3C3C * (p + 1) + 32'h1234_5678 * p;
         mb = 32'hA5A5_F00F ^ (32'h0F0F_1111 * p);
         wr(8'h28, 32'hFFFF_FFFF);
         wr(8'h24, sa);
         wr(8'h2c, mb);
         rd(8'h38, v); chk("R6 masked view", v, sa & mb & DEF);
      end

      // R2 event line field positions
      do_reset();
      for (int i = 0; i < TXW + RXW + CW; i++) begin
         logic [31:0] e;
         @(negedge clk);
         if (i < TXW) begin
            tx_evt = TXW'(1) << i; e = 32'd1 << i;
         end else if (i < TXW + RXW) begin
            rx_evt = RXW'(1) << (i - TXW); e = 32'd1 << (9 + i - TXW);
         end else begin
            core_evt = CW'(1) << (i - TXW - RXW); e = 32'd1 << (16 + i - TXW - RXW);
         end
         @(negedge clk);
         tx_evt = '0; rx_evt = '0; core_evt = '0;
         rd(8'h20, v); chk("R2 event field position", v, e);
         wr(8'h28, e);
      end

      // R4 event beats same-cycle clear
      wr(8'h24, 32'h0000_0004);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h0000_0006;
      tx_evt = 5'b00100;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0; tx_evt = '0;
      rd(8'h20, v); chk("R4 event wins over clear", v, 32'h0000_0004);

      // R8 / R9 / R10 interrupt sequence
      do_reset();
      wr(8'h2c, 32'h0100_0001);
      wr(8'h24, 32'h0000_0002);
      @(negedge clk);
      chk("R8 unmasked source no irq", {31'd0, irq_o}, 32'h0);
      wr(8'h24, 32'h0100_0000);
      chk("R8 irq not yet", {31'd0, irq_o}, 32'h0);
      @(negedge clk);
      chk("R8 irq rises", {31'd0, irq_o}, 32'h1);
      wr(8'h28, 32'h0100_0000);
      chk("R8 irq still high at clear edge", {31'd0, irq_o}, 32'h1);
      @(negedge clk);
      chk("R8 irq falls", {31'd0, irq_o}, 32'h0);
      wr(8'h24, 32'h0000_0001);
      repeat (5) @(negedge clk);
      chk("R9 irq held low while disarmed", {31'd0, irq_o}, 32'h0);
      wr(8'h3c, 32'h0);
      chk("R10 eoi raises irq", {31'd0, irq_o}, 32'h1);
      wr(8'h28, 32'h0000_0001);
      @(negedge clk);
      chk("R8 irq falls again", {31'd0, irq_o}, 32'h0);
      wr(8'h3c, 32'hDEAD_BEEF);
      @(negedge clk);
      chk("R10 eoi without pending keeps low", {31'd0, irq_o}, 32'h0);
      @(negedge clk);
      core_evt = 9'h100;
      @(negedge clk);
      core_evt = '0;
      @(negedge clk);
      chk("R8 R2 rearmed event raises irq", {31'd0, irq_o}, 32'h1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule